// File: doc/BRIEF.md
# Unsigned BCD Vector Shifter

This unit moves a 128-bit vector of 32 unsigned packed BCD digits left or right by a whole number of digits. Each digit sits in its own nibble, and there is no sign nibble, so the lowest nibble is an ordinary digit. The distance is a signed byte taken from a fixed field of a second 128-bit operand. A positive distance shifts toward the most significant digit and a negative one shifts toward the least significant digit. Zero digits fill the vacated positions.

Every digit is checked before the result is accepted. If any nibble holds a code above nine, the operation is refused. In that case the stored result keeps its previous value, the write-enable stays low, and the condition code reports only the summary-overflow flag. For valid data, the unit registers the shifted vector, a one-cycle write-enable and a condition code. The condition code compares the result with zero and adds an overflow flag when a nonzero digit leaves the top of the vector. Distances at or beyond the vector length clear the result.

Top module: `bcd_ushift_unit`

## Requirements
- R1: Operand `opb_i` holds 32 digits, with digit i in bits [4i+3:4i]. All 32 digits, including digit 0, are data digits with no sign role.
- R2: If any digit of `opb_i` has a value of 10 to 15, the next cycle shows `cc_o` = 4'b0001 and `wr_en_o` low, and `result_o` keeps its previous value.
- R3: The shift distance is the two's-complement byte `opa_i[71:64]`. All other bits of `opa_i` have no effect.
- R4: A distance k from 1 to 31 gives `opb_i` shifted left by 4k bits with zero fill. SO (`cc_o[0]`) is set exactly when at least one of the k digits shifted out is nonzero.
- R5: A distance k from -31 to -1 gives `opb_i` shifted right by 4|k| bits with zero fill at the top. SO is never set by the digits that are dropped.
- R6: A distance of 32 or more gives a zero result with SO set, so `cc_o` = 4'b0011.
- R7: A distance of -32 or less gives a zero result with SO clear, so `cc_o` = 4'b0010.
- R8: A distance of 0 passes `opb_i` through unchanged with SO clear.
- R9: For valid data, `cc_o` is {LT,GT,EQ,SO} in bits [3:0]. LT is always 0. EQ is set when the result is zero, and GT is set when it is nonzero.
- R10: Outputs are registered. One cycle after `valid_i`, `wr_en_o` pulses for exactly one cycle if the data is valid. When no strobe arrives, `wr_en_o` stays low and `result_o` and `cc_o` hold their values.
- R11: While `rst_ni` is low, `result_o`, `cc_o` and `wr_en_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| opa_i | input | 128 | Operand carrying the signed digit distance in bits [71:64] |
| opb_i | input | 128 | 32 packed unsigned BCD digits to shift |
| result_o | output | 128 | Registered shifted result |
| wr_en_o | output | 1 | Result write-enable, one cycle after a valid operation |
| cc_o | output | 4 | Condition code {LT,GT,EQ,SO} |

## Verification
Random valid digit vectors, some with leading zero digits, are shifted by distances across the full byte range. This shows whether overflow tracks the nonzero digits that are lost, and not merely any digit that moves out. Directed cases at distances of 31, 32, -31, -32, 127, -128 and 0 test the clear boundaries and the pass-through case. Vectors with one illegal nibble, placed at random or in digit 0, test that the result is held and the code is reduced to SO. Junk in the unused bits of the distance operand tests that only the one byte is decoded.

// File: rtl/bcd_ushift_pkg.sv
package bcd_ushift_pkg;
  localparam int unsigned CC_W = 4;
  localparam int unsigned CC_LT = 3;
  localparam int unsigned CC_GT = 2;
  localparam int unsigned CC_EQ = 1;
  localparam int unsigned CC_SO = 0;
  localparam int unsigned BCD_MAX = 9;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_code_t;
endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check #(
  parameter int unsigned DIGITS = 32,
  parameter int unsigned DIG_W  = 4,
  localparam int unsigned W     = DIGITS * DIG_W
) (
  input  logic [W-1:0] data_i,
  output logic         all_ok_o
);
  import bcd_ushift_pkg::*;

  logic [DIGITS-1:0] dig_ok;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign dig_ok[i] = (data_i[i*DIG_W +: DIG_W] <= DIG_W'(BCD_MAX));
  end

  assign all_ok_o = &dig_ok;
endmodule

// File: rtl/bcd_count_decode.sv
module bcd_count_decode #(
  parameter int unsigned DIGITS = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned AW    = $clog2(DIGITS)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             left_o,
  output logic [AW-1:0]    amt_o,
  output logic             clr_o,
  output logic             clr_ovf_o
);
  logic signed [CNT_W-1:0] cnt_s;
  logic signed [CNT_W-1:0] cnt_neg;
  int                      cnt_int;

  assign cnt_s   = $signed(cnt_i);
  assign cnt_neg = -cnt_s;
  assign cnt_int = int'(cnt_s);

  always_comb begin
    left_o    = 1'b0;
    amt_o     = '0;
    clr_o     = 1'b0;
    clr_ovf_o = 1'b0;
    if (cnt_int >= int'(DIGITS)) begin
      clr_o     = 1'b1;
      clr_ovf_o = 1'b1;
    end else if (cnt_int <= -int'(DIGITS)) begin
      clr_o = 1'b1;
    end else if (cnt_int > 0) begin
      left_o = 1'b1;
      amt_o  = cnt_s[AW-1:0];
    end else begin
      amt_o = cnt_neg[AW-1:0];
    end
  end
endmodule

// File: rtl/bcd_digit_shifter.sv
module bcd_digit_shifter #(
  parameter int unsigned DIGITS = 32,
  parameter int unsigned DIG_W  = 4,
  localparam int unsigned W     = DIGITS * DIG_W,
  localparam int unsigned AW    = $clog2(DIGITS)
) (
  input  logic [W-1:0]  data_i,
  input  logic          left_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o,
  output logic          lost_o
);
  logic [W-1:0] stg  [AW+1];
  logic         lost [AW+1];

  assign stg[0]  = data_i;
  assign lost[0] = 1'b0;

  // log-depth barrel, one stage per distance bit
  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned SH = (1 << s) * DIG_W;
    logic [W-1:0] shl;
    logic [W-1:0] shr;
    logic         top_nz;

    assign shl    = stg[s] << SH;
    assign shr    = stg[s] >> SH;
    assign top_nz = |stg[s][W-1 -: SH];

    assign stg[s+1]  = !amt_i[s] ? stg[s] : (left_i ? shl : shr);
    assign lost[s+1] = lost[s] | (amt_i[s] & left_i & top_nz);
  end

  assign data_o = stg[AW];
  assign lost_o = lost[AW];
endmodule

// File: rtl/bcd_cc_gen.sv
module bcd_cc_gen #(
  parameter int unsigned W = 128
) (
  input  logic [W-1:0]                   res_i,
  input  logic                           ovf_i,
  input  logic                           ok_i,
  output bcd_ushift_pkg::cond_code_t     cc_o
);
  logic is_zero;

  assign is_zero = (res_i == '0);

  always_comb begin
    cc_o    = '0;
    cc_o.so = 1'b1;
    if (ok_i) begin
      cc_o.lt = 1'b0;
      cc_o.gt = !is_zero;
      cc_o.eq = is_zero;
      cc_o.so = ovf_i;
    end
  end
endmodule

// File: rtl/bcd_ushift_unit.sv
module bcd_ushift_unit #(
  parameter int unsigned DIGITS  = 32,
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned CNT_LSB = 64,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned W      = DIGITS * DIG_W,
  localparam int unsigned AW     = $clog2(DIGITS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   cc_o
);
  import bcd_ushift_pkg::*;

  logic          all_ok;
  logic          left;
  logic [AW-1:0] amt;
  logic          clr;
  logic          clr_ovf;
  logic [W-1:0]  shifted;
  logic          lost;
  logic [W-1:0]  res_d;
  logic          ovf_d;
  cond_code_t    cc_d;

  logic [W-1:0]  result_q;
  logic          wr_en_q;
  cond_code_t    cc_q;

  bcd_digit_check #(.DIGITS(DIGITS), .DIG_W(DIG_W)) i_check (
    .data_i   (opb_i),
    .all_ok_o (all_ok)
  );

  bcd_count_decode #(.DIGITS(DIGITS), .CNT_W(CNT_W)) i_decode (
    .cnt_i     (opa_i[CNT_LSB +: CNT_W]),
    .left_o    (left),
    .amt_o     (amt),
    .clr_o     (clr),
    .clr_ovf_o (clr_ovf)
  );

  bcd_digit_shifter #(.DIGITS(DIGITS), .DIG_W(DIG_W)) i_shift (
    .data_i (opb_i),
    .left_i (left),
    .amt_i  (amt),
    .data_o (shifted),
    .lost_o (lost)
  );

  assign res_d = clr ? '0 : shifted;
  assign ovf_d = clr ? clr_ovf : lost;

  bcd_cc_gen #(.W(W)) i_cc (
    .res_i (res_d),
    .ovf_i (ovf_d),
    .ok_i  (all_ok),
    .cc_o  (cc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      wr_en_q  <= 1'b0;
      cc_q     <= '0;
    end else begin
      wr_en_q <= valid_i & all_ok;
      if (valid_i) cc_q <= cc_d;
      if (valid_i && all_ok) result_q <= res_d;
    end
  end

  assign result_o = result_q;
  assign wr_en_o  = wr_en_q;
  assign cc_o     = cc_q;
endmodule

// File: rtl/bcd_ushift_unit_chk.sv
module bcd_ushift_unit_chk #(
  parameter int unsigned DIGITS  = 32,
  parameter int unsigned DIG_W   = 4,
  parameter int unsigned CNT_LSB = 64,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned W      = DIGITS * DIG_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   cc_o
);
  int cnt_int;
  assign cnt_int = int'($signed(opa_i[CNT_LSB +: CNT_W]));

  AST_LT_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (cc_o[3] == 1'b0 && $onehot(cc_o[2:1]))); // R9

  AST_EQ_MATCHES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (cc_o[1] == (result_o == '0))); // R9

  AST_WREN_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i)); // R10

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable(result_o)); // R2

  AST_REJECT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && !wr_en_o) |-> (cc_o == 4'b0001)); // R2

  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_int == 0) |=>
      (!wr_en_o || (result_o == $past(opb_i) && !cc_o[0]))); // R8

  AST_FAR_LEFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_int >= int'(DIGITS)) |=>
      (!wr_en_o || (result_o == '0 && cc_o == 4'b0011))); // R6

  AST_FAR_RIGHT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_int <= -int'(DIGITS)) |=>
      (!wr_en_o || (result_o == '0 && cc_o == 4'b0010))); // R7

  AST_RIGHT_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_int < 0) |=> !cc_o[0] || !wr_en_o); // R5
endmodule

bind bcd_ushift_unit bcd_ushift_unit_chk #(
  .DIGITS (DIGITS),
  .DIG_W  (DIG_W),
  .CNT_LSB(CNT_LSB),
  .CNT_W  (CNT_W)
) i_chk (.*);

// File: tb/test_bcd_ushift_unit.sv
`timescale 1ns/1ps
module test_bcd_ushift_unit;
  localparam int N  = 32;
  localparam int W  = 128;
  localparam int WD_CYCLES = 50000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] opa_i = '0;
  logic [W-1:0] opb_i = '0;
  logic [W-1:0] result_o;
  logic         wr_en_o;
  logic [3:0]   cc_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] held_res = '0;
  logic [3:0]   held_cc  = '0;

  always #2 clk_i = ~clk_i;

  bcd_ushift_unit i_bcd_ushift_unit (
    .clk_i, .rst_ni, .valid_i, .opa_i, .opb_i, .result_o, .wr_en_o, .cc_o
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit digits_ok(input logic [W-1:0] b);
    for (int i = 0; i < N; i++) if (b[i*4 +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  // digit-array reference
  function automatic void ref_op(input logic [W-1:0] b, input logic [7:0] c,
                                 output logic [W-1:0] r, output logic ov);
    int k;
    logic [3:0] d [N];
    k  = int'($signed(c));
    ov = 1'b0;
    r  = '0;
    for (int i = 0; i < N; i++) d[i] = b[i*4 +: 4];
    if (k >= N) begin
      ov = 1'b1;
    end else if (k <= -N) begin
      ov = 1'b0;
    end else if (k >= 0) begin
      for (int i = 0; i < N; i++) if (i >= k) r[i*4 +: 4] = d[i-k];
      for (int j = N - k; j < N; j++) if (d[j] != 0) ov = 1'b1;
    end else begin
      for (int i = 0; i < N; i++) if (i - k < N) r[i*4 +: 4] = d[i-k];
    end
  endfunction

  function automatic logic [W-1:0] rand_bcd(input int zero_top);
    logic [W-1:0] v = '0;
    for (int i = 0; i < N - zero_top; i++) v[i*4 +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  function automatic logic [W-1:0] rand_wide();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    logic eo;
    logic [3:0] ec;
    bit ok;
    ok = digits_ok(b);
    ref_op(b, a[71:64], er, eo);
    @(negedge clk_i);
    opa_i = a; opb_i = b; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (ok) begin
      ec = {1'b0, er != '0, er == '0, eo};
      held_res = er;
    end else begin
      ec = 4'b0001;
    end
    held_cc = ec;
    chk({req, " result"}, result_o, held_res);
    chk({req, " cc"}, W'(cc_o), W'(ec));
    chk({req, " wr_en"}, W'(wr_en_o), W'(ok));
  endtask

  function automatic logic [W-1:0] with_cnt(input logic [7:0] c);
    logic [W-1:0] a = rand_wide();
    a[71:64] = c;
    return a;
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] b;
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk("R11 result", result_o, '0);
    chk("R11 cc", W'(cc_o), '0);
    chk("R11 wr_en", W'(wr_en_o), '0);
    rst_ni = 1'b1;

    // directed corners
    b = rand_bcd(0); b[N*4-4 +: 4] = 4'd7;
    run_op("R8 zero count", with_cnt(8'd0), b);
    run_op("R3 junk around byte", {{56{1'b1}}, 8'd0, {64{1'b1}}}, b);
    run_op("R4 left 31 lost", with_cnt(8'd31), b);
    run_op("R4 left 1 from digit0", with_cnt(8'd1), W'(4'd5));
    run_op("R6 left 32", with_cnt(8'd32), b);
    run_op("R6 left 127", with_cnt(8'd127), b);
    run_op("R5 right 31", with_cnt(8'hE1), b);
    run_op("R7 right 32", with_cnt(8'hE0), b);
    run_op("R7 right 128", with_cnt(8'h80), b);
    run_op("R6 zero data left 40", with_cnt(8'd40), '0);
    run_op("R4 left 31 no loss", with_cnt(8'd31), W'(4'd3));
    // R1 digit 0 is a data digit: nonzero low nibble must shift as a digit
    run_op("R1 low digit moves", with_cnt(8'd2), W'(4'd9));
    b = rand_bcd(0); b[3:0] = 4'hA;
    run_op("R2 bad low digit", with_cnt(8'd3), b);
    b = rand_bcd(0); b[N*4-4 +: 4] = 4'hF;
    run_op("R2 bad top digit", with_cnt(8'hFD), b);

    // R10 idle: no strobe, outputs hold
    @(negedge clk_i);
    chk("R10 idle wr_en", W'(wr_en_o), '0);
    chk("R10 idle result", result_o, held_res);
    chk("R10 idle cc", W'(cc_o), W'(held_cc));

    // constrained random
    for (int t = 0; t < 400; t++) begin
      logic [7:0] c;
      int sel;
      sel = int'($urandom % 10);
      if (sel == 0)      c = 8'($urandom);
      else               c = 8'(int'($urandom % 81) - 40);
      b = rand_bcd(int'($urandom % 33));
      if (($urandom % 10) == 0) b[($urandom % N)*4 +: 4] = 4'(10 + $urandom % 6);
      if (c[7]) run_op("R5/R7 random", with_cnt(c), b);
      else      run_op("R4/R6/R8 random", with_cnt(c), b);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule